// File: doc/BRIEF.md
# Bidirectional Dual-Clock FIFO Pair

This block joins two clock domains, side A on `a_clk` and side B on `b_clk`, with two independent first-in first-out queues running in opposite directions. Queue AB takes words written on side A and hands them out on side B. Queue BA does the reverse. Each side has the same four control lines: an active-low select, a direction bit, an enable and a mailbox bit. Together they decide on each rising edge of that side's clock whether the side pushes into its outbound queue, pops from its inbound queue, or does nothing.

Each side reports two active-low threshold flags. One warns that its outbound queue is close to full. The other warns that its inbound queue is close to empty. Both flags change only on the side's own clock. A flag is set by the side's own access at the next edge of that clock. A flag cleared by activity on the far side waits for that side's pointer to cross a two-stage Gray-code synchronizer, so clearing takes two or three local edges, depending on how close the two clock edges were. The port keeps the plain select/enable handshake, so there is no valid/ready pair. Back-pressure comes from the flags: a writer that stops while its almost-full flag is low, or a reader that pops only while its almost-empty flag is high, can never be refused.

Top module: `bidir_fifo_pair`

## Requirements
- R1: Words pushed on side A come out on side B complete (36 bits) and in push order. Queue AB holds up to 64 words.
- R2: Words pushed on side B come out on side A complete (36 bits) and in push order. Queue BA holds up to 64 words.
- R3: A side pushes at a rising edge of its clock only when select is 0, direction is 1, mailbox is 0 and enable is 1. A high select, a high mailbox bit or a low enable makes the edge a no-op.
- R4: A side pops at a rising edge of its clock only when select is 0, direction is 0, mailbox is 0 and enable is 1. The popped word appears on that side's read-data port after the edge and holds there until the next pop.
- R5: The almost-full flag of a side is 0 while its outbound queue holds 64-X or more words and 1 otherwise. A push that reaches the threshold drives it to 0 at that same edge.
- R6: The almost-empty flag of a side is 0 while its inbound queue holds X or fewer words and 1 otherwise. A pop that reaches the threshold drives it to 0 at that same edge.
- R7: A far-side pop that brings the count below 64-X, or a far-side push that brings it above X, releases the matching flag to 1 within three rising edges of the flag's own clock.
- R8: A push into a full queue and a pop from an empty queue are ignored. The pointers stay put, no word is lost or duplicated, and the read-data port keeps its value.
- R9: While `rst_n` is 0, both queues are empty, both almost-empty flags are 0, both almost-full flags are 1 and both read-data ports are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Side A clock |
| b_clk | input | 1 | Side B clock |
| rst_n | input | 1 | Asynchronous reset, active low, both sides |
| a_sel_n | input | 1 | Side A select, active low |
| a_dir_wr | input | 1 | Side A direction: 1 push, 0 pop |
| a_en | input | 1 | Side A access enable |
| a_mbx | input | 1 | Side A mailbox bit; 1 suppresses queue access |
| a_wdata | input | 36 | Side A push data into queue AB |
| a_rdata | output | 36 | Side A pop data from queue BA |
| a_almost_full_n | output | 1 | Queue AB almost full, active low, on a_clk |
| a_almost_empty_n | output | 1 | Queue BA almost empty, active low, on a_clk |
| b_sel_n | input | 1 | Side B select, active low |
| b_dir_wr | input | 1 | Side B direction: 1 push, 0 pop |
| b_en | input | 1 | Side B access enable |
| b_mbx | input | 1 | Side B mailbox bit; 1 suppresses queue access |
| b_wdata | input | 36 | Side B push data into queue BA |
| b_rdata | output | 36 | Side B pop data from queue AB |
| b_almost_full_n | output | 1 | Queue BA almost full, active low, on b_clk |
| b_almost_empty_n | output | 1 | Queue AB almost empty, active low, on b_clk |

## Verification
The transfer path is driven first with one-sided bursts from a table. These raise each queue past both thresholds, fill it to 64 and drain it to zero while the far side is idle, so every flag can be compared with the exact count after each access. Next comes a free-running stream in which side A pushes while side B pops at an unrelated clock rate, each gated only by its flags. This separates correct Gray-pointer crossing from schemes that work only when the two domains take turns. Directed cases then try every suppressing control combination, push into a full queue, pop from an empty one, and time flag release in local edges, which separates a two-stage release path from one that is too slow.

// File: rtl/bfifo_pkg.sv
package bfifo_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_PUSH = 2'd1,
    ACC_POP  = 2'd2
  } access_e;

  // Side control decode: any suppressing line gives IDLE.
  function automatic access_e decode_side(input logic sel_n, input logic dir_wr,
                                          input logic en, input logic mbx);
    if (sel_n || mbx || !en) return ACC_IDLE;
    return dir_wr ? ACC_PUSH : ACC_POP;
  endfunction

endpackage

// File: rtl/gray_ptr_sync.sv
module gray_ptr_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] gray_out
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1   <= '0;
      gray_out <= '0;
    end else begin
      stage1   <= gray_in;
      gray_out <= stage1;
    end
  end
endmodule

// File: rtl/fifo_push_ctl.sv
module fifo_push_ctl #(
  parameter int DEPTH = 64,
  parameter int THRESH_X = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [PW-1:0] pop_gray_s,
  output logic          push_fire,
  output logic [AW-1:0] push_addr,
  output logic [PW-1:0] push_gray,
  output logic          almost_full_n
);
  logic [PW-1:0] push_bin, pop_bin_s, used, push_bin_nxt;
  logic          full;

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_comb begin
    pop_bin_s     = gray2bin(pop_gray_s);
    used          = push_bin - pop_bin_s;
    full          = (used == PW'(DEPTH));
    push_fire     = push_req && !full;
    push_bin_nxt  = push_bin + PW'(1);
    push_addr     = push_bin[AW-1:0];
    almost_full_n = !(used >= PW'(DEPTH - THRESH_X));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_bin  <= '0;
      push_gray <= '0;
    end else if (push_fire) begin
      push_bin  <= push_bin_nxt;
      push_gray <= push_bin_nxt ^ (push_bin_nxt >> 1);
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    used <= PW'(DEPTH));

  assert_full_push_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req) |=> $stable(push_bin));

  assert_af_falls_on_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(almost_full_n) |-> $past(push_fire));

  assert_gray_single_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(push_gray ^ $past(push_gray)) <= 1);
endmodule

// File: rtl/fifo_pop_ctl.sv
module fifo_pop_ctl #(
  parameter int DEPTH = 64,
  parameter int THRESH_X = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop_req,
  input  logic [PW-1:0] push_gray_s,
  output logic          pop_fire,
  output logic [AW-1:0] pop_addr,
  output logic [PW-1:0] pop_gray,
  output logic          almost_empty_n
);
  logic [PW-1:0] pop_bin, push_bin_s, used, pop_bin_nxt;
  logic          empty;

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_comb begin
    push_bin_s     = gray2bin(push_gray_s);
    used           = push_bin_s - pop_bin;
    empty          = (used == '0);
    pop_fire       = pop_req && !empty;
    pop_bin_nxt    = pop_bin + PW'(1);
    pop_addr       = pop_bin[AW-1:0];
    almost_empty_n = !(used <= PW'(THRESH_X));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pop_bin  <= '0;
      pop_gray <= '0;
    end else if (pop_fire) begin
      pop_bin  <= pop_bin_nxt;
      pop_gray <= pop_bin_nxt ^ (pop_bin_nxt >> 1);
    end
  end

  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req) |=> $stable(pop_bin));

  assert_used_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    used <= PW'(DEPTH));

  assert_ae_falls_on_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(almost_empty_n) |-> $past(pop_fire));
endmodule

// File: rtl/cdc_fifo.sv
module cdc_fifo #(
  parameter int DATA_W = 36,
  parameter int DEPTH = 64,
  parameter int THRESH_X = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic              push_clk,
  input  logic              pop_clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] pop_data,
  output logic              almost_full_n,
  output logic              almost_empty_n
);
  logic              push_fire, pop_fire;
  logic [AW-1:0]     push_addr, pop_addr;
  logic [PW-1:0]     push_gray, pop_gray, push_gray_s, pop_gray_s;
  logic [DATA_W-1:0] store [DEPTH];

  fifo_push_ctl #(.DEPTH(DEPTH), .THRESH_X(THRESH_X)) u_push (
    .clk(push_clk), .rst_n(rst_n), .push_req(push_req), .pop_gray_s(pop_gray_s),
    .push_fire(push_fire), .push_addr(push_addr), .push_gray(push_gray),
    .almost_full_n(almost_full_n));

  fifo_pop_ctl #(.DEPTH(DEPTH), .THRESH_X(THRESH_X)) u_pop (
    .clk(pop_clk), .rst_n(rst_n), .pop_req(pop_req), .push_gray_s(push_gray_s),
    .pop_fire(pop_fire), .pop_addr(pop_addr), .pop_gray(pop_gray),
    .almost_empty_n(almost_empty_n));

  gray_ptr_sync #(.W(PW)) u_sync_to_pop (
    .clk(pop_clk), .rst_n(rst_n), .gray_in(push_gray), .gray_out(push_gray_s));

  gray_ptr_sync #(.W(PW)) u_sync_to_push (
    .clk(push_clk), .rst_n(rst_n), .gray_in(pop_gray), .gray_out(pop_gray_s));

  always_ff @(posedge push_clk) begin
    if (push_fire) store[push_addr] <= push_data;
  end

  always_ff @(posedge pop_clk or negedge rst_n) begin
    if (!rst_n)        pop_data <= '0;
    else if (pop_fire) pop_data <= store[pop_addr];
  end

  assert_rdata_hold_R4: assert property (@(posedge pop_clk) disable iff (!rst_n)
    !pop_fire |=> $stable(pop_data));
endmodule

// File: rtl/bidir_fifo_pair.sv
module bidir_fifo_pair #(
  parameter int DATA_W = 36,
  parameter int DEPTH = 64,
  parameter int THRESH_X = 8
) (
  input  logic              a_clk,
  input  logic              b_clk,
  input  logic              rst_n,
  input  logic              a_sel_n,
  input  logic              a_dir_wr,
  input  logic              a_en,
  input  logic              a_mbx,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_almost_full_n,
  output logic              a_almost_empty_n,
  input  logic              b_sel_n,
  input  logic              b_dir_wr,
  input  logic              b_en,
  input  logic              b_mbx,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_almost_full_n,
  output logic              b_almost_empty_n
);
  import bfifo_pkg::*;

  access_e a_acc, b_acc;
  logic    a_push, a_pop, b_push, b_pop;

  always_comb begin
    a_acc  = decode_side(a_sel_n, a_dir_wr, a_en, a_mbx);
    b_acc  = decode_side(b_sel_n, b_dir_wr, b_en, b_mbx);
    a_push = (a_acc == ACC_PUSH);
    a_pop  = (a_acc == ACC_POP);
    b_push = (b_acc == ACC_PUSH);
    b_pop  = (b_acc == ACC_POP);
  end

  // Queue AB: side A pushes, side B pops.
  cdc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .THRESH_X(THRESH_X)) u_q_ab (
    .push_clk(a_clk), .pop_clk(b_clk), .rst_n(rst_n),
    .push_req(a_push), .push_data(a_wdata), .pop_req(b_pop), .pop_data(b_rdata),
    .almost_full_n(a_almost_full_n), .almost_empty_n(b_almost_empty_n));

  // Queue BA: side B pushes, side A pops.
  cdc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .THRESH_X(THRESH_X)) u_q_ba (
    .push_clk(b_clk), .pop_clk(a_clk), .rst_n(rst_n),
    .push_req(b_push), .push_data(b_wdata), .pop_req(a_pop), .pop_data(a_rdata),
    .almost_full_n(b_almost_full_n), .almost_empty_n(a_almost_empty_n));

  assert_a_mbx_blocks_R3: assert property (@(posedge a_clk) disable iff (!rst_n)
    a_mbx |-> !(a_push || a_pop));
endmodule

// File: tb/bidir_fifo_pair_test.sv
module bidir_fifo_pair_test;
  localparam int CLK_A_PERIOD = 10;
  localparam int CLK_B_PERIOD = 14;
  localparam int DW = 36;
  localparam int DEPTH = 64;
  localparam int X = 8;
  localparam int NSTEP = 9;
  // step = {queue (0 AB, 1 BA), push (1) / pop (0), count}
  localparam logic [9:0] STEPS [NSTEP] = '{
    {1'b0, 1'b1, 8'd60}, {1'b0, 1'b0, 8'd52}, {1'b1, 1'b1, 8'd10},
    {1'b1, 1'b0, 8'd2},  {1'b0, 1'b1, 8'd3},  {1'b0, 1'b0, 8'd11},
    {1'b1, 1'b0, 8'd8},  {1'b1, 1'b1, 8'd64}, {1'b1, 1'b0, 8'd64}};

  logic a_clk = 0, b_clk = 0, rst_n = 0;
  logic a_sel_n = 1, a_dir_wr = 0, a_en = 0, a_mbx = 0;
  logic b_sel_n = 1, b_dir_wr = 0, b_en = 0, b_mbx = 0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0, a_rdata, b_rdata;
  logic a_almost_full_n, a_almost_empty_n, b_almost_full_n, b_almost_empty_n;

  int checks = 0, failures = 0;
  logic [DW-1:0] q_ab[$], q_ba[$];
  logic [DW-1:0] seed = 36'h5_0000_0000;
  bit done = 0;

  always #(CLK_A_PERIOD/2) a_clk = ~a_clk;
  always #(CLK_B_PERIOD/2) b_clk = ~b_clk;

  bidir_fifo_pair #(.DATA_W(DW), .DEPTH(DEPTH), .THRESH_X(X)) uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic a_op(input logic dir, input logic [DW-1:0] d, input logic sel_n,
                      input logic mbx, input logic en);
    @(negedge a_clk);
    a_sel_n = sel_n; a_dir_wr = dir; a_mbx = mbx; a_en = en; a_wdata = d;
    @(posedge a_clk); #1;
    a_en = 0; a_sel_n = 1; a_mbx = 0;
  endtask

  task automatic b_op(input logic dir, input logic [DW-1:0] d, input logic sel_n,
                      input logic mbx, input logic en);
    @(negedge b_clk);
    b_sel_n = sel_n; b_dir_wr = dir; b_mbx = mbx; b_en = en; b_wdata = d;
    @(posedge b_clk); #1;
    b_en = 0; b_sel_n = 1; b_mbx = 0;
  endtask

  task automatic a_push();
    seed++;
    a_op(1, seed, 0, 0, 1);
    q_ab.push_back(seed);
  endtask

  task automatic b_push();
    seed++;
    b_op(1, seed, 0, 0, 1);
    q_ba.push_back(seed);
  endtask

  task automatic b_pop(input string tag);
    logic [DW-1:0] e;
    e = q_ab.pop_front();
    b_op(0, '0, 0, 0, 1);
    chk(b_rdata === e, tag, b_rdata, e);
  endtask

  task automatic a_pop(input string tag);
    logic [DW-1:0] e;
    e = q_ba.pop_front();
    a_op(0, '0, 0, 0, 1);
    chk(a_rdata === e, tag, a_rdata, e);
  endtask

  function automatic logic af_exp(input int n); return !(n >= DEPTH - X); endfunction
  function automatic logic ae_exp(input int n); return !(n <= X); endfunction

  task automatic settle();
    repeat (4) @(posedge a_clk);
    repeat (4) @(posedge b_clk);
    #1;
  endtask

  task automatic flags_all(input string tag);
    chk(a_almost_full_n === af_exp(q_ab.size()), {tag, " R5 A af"}, a_almost_full_n, af_exp(q_ab.size()));
    chk(b_almost_empty_n === ae_exp(q_ab.size()), {tag, " R6 B ae"}, b_almost_empty_n, ae_exp(q_ab.size()));
    chk(b_almost_full_n === af_exp(q_ba.size()), {tag, " R5 B af"}, b_almost_full_n, af_exp(q_ba.size()));
    chk(a_almost_empty_n === ae_exp(q_ba.size()), {tag, " R6 A ae"}, a_almost_empty_n, ae_exp(q_ba.size()));
  endtask

  initial begin
    #(CLK_A_PERIOD * 150000);
    chk(0, "watchdog", '0, '1);
    summary();
  end

  initial begin
    logic [DW-1:0] held;
    int k;
    repeat (3) @(posedge a_clk);
    #1;
    // R9 reset state
    chk(a_almost_empty_n === 0 && b_almost_empty_n === 0, "R9 ae in reset", {a_almost_empty_n, b_almost_empty_n}, 0);
    chk(a_almost_full_n === 1 && b_almost_full_n === 1, "R9 af in reset", {a_almost_full_n, b_almost_full_n}, 3);
    chk(a_rdata === 0 && b_rdata === 0, "R9 rdata in reset", a_rdata | b_rdata, 0);
    @(negedge a_clk); rst_n = 1;
    settle();
    flags_all("R9 after reset");

    // Table of one-sided bursts: R1 R2 data, R5 R6 flags after each own access
    for (int s = 0; s < NSTEP; s++) begin
      for (int i = 0; i < int'(STEPS[s][7:0]); i++) begin
        case (STEPS[s][9:8])
          2'b01: begin a_push(); chk(a_almost_full_n === af_exp(q_ab.size()), "R5 A af on push", a_almost_full_n, af_exp(q_ab.size())); end
          2'b00: begin b_pop("R1 AB order"); chk(b_almost_empty_n === ae_exp(q_ab.size()), "R6 B ae on pop", b_almost_empty_n, ae_exp(q_ab.size())); end
          2'b11: begin b_push(); chk(b_almost_full_n === af_exp(q_ba.size()), "R5 B af on push", b_almost_full_n, af_exp(q_ba.size())); end
          default: begin a_pop("R2 BA order"); chk(a_almost_empty_n === ae_exp(q_ba.size()), "R6 A ae on pop", a_almost_empty_n, ae_exp(q_ba.size())); end
        endcase
      end
      settle();
      flags_all("table step");
    end

    // R3: suppressed pushes leave queue AB empty
    for (int i = 0; i < X + 1; i++) begin
      a_op(1, 36'hBAD, 1, 0, 1);
      a_op(1, 36'hBAD, 0, 1, 1);
      a_op(1, 36'hBAD, 0, 0, 0);
    end
    settle();
    chk(b_almost_empty_n === 0, "R3 suppressed push count", b_almost_empty_n, 0);
    a_push(); a_push();
    settle();
    // R4: suppressed pops leave rdata and queue untouched
    held = b_rdata;
    b_op(0, '0, 0, 1, 1);
    chk(b_rdata === held, "R4 mailbox pop ignored", b_rdata, held);
    b_op(0, '0, 0, 0, 0);
    chk(b_rdata === held, "R4 disabled pop ignored", b_rdata, held);
    b_op(0, '0, 1, 0, 1);
    chk(b_rdata === held, "R4 deselected pop ignored", b_rdata, held);
    b_pop("R3 first valid word");
    b_pop("R4 second valid word");

    // R8: push into full, pop from empty
    for (int i = 0; i < DEPTH; i++) a_push();
    a_op(1, 36'hDEAD, 0, 0, 1);
    chk(a_almost_full_n === 0, "R8 full af", a_almost_full_n, 0);
    settle();
    for (int i = 0; i < DEPTH; i++) b_pop("R8 full contents intact");
    settle();
    held = b_rdata;
    b_op(0, '0, 0, 0, 1);
    chk(b_rdata === held, "R8 empty pop ignored", b_rdata, held);
    a_push();
    settle();
    b_pop("R8 pointers unmoved");

    // R7: release latency of almost-full on A after a B pop
    for (int i = 0; i < DEPTH - X; i++) a_push();
    settle();
    chk(a_almost_full_n === 0, "R7 af set", a_almost_full_n, 0);
    b_pop("R7 release pop");
    k = 0;
    for (int e = 1; e <= 5; e++) begin
      @(posedge a_clk); #1;
      if (a_almost_full_n === 1 && k == 0) k = e;
    end
    chk(k >= 1 && k <= 3, "R7 af release edges", k, 3);
    while (q_ab.size() > X) b_pop("R7 drain");
    settle();
    chk(b_almost_empty_n === 0, "R7 ae set", b_almost_empty_n, 0);
    a_push();
    k = 0;
    for (int e = 1; e <= 5; e++) begin
      @(posedge b_clk); #1;
      if (b_almost_empty_n === 1 && k == 0) k = e;
    end
    chk(k >= 1 && k <= 3, "R7 ae release edges", k, 3);
    while (q_ab.size() > 0) b_pop("R7 drain");
    settle();

    // Concurrent stream at unrelated clocks, flag-gated: R1
    fork
      begin
        for (int i = 0; i < 200; i++) begin
          while (a_almost_full_n !== 1) begin @(posedge a_clk); #1; end
          a_push();
        end
        done = 1;
      end
      begin
        while (!(done && b_almost_empty_n !== 1)) begin
          if (b_almost_empty_n === 1) b_pop("R1 stream order");
          else begin @(posedge b_clk); #1; end
        end
      end
    join
    settle();
    while (q_ab.size() > 0) b_pop("R1 stream drain");
    settle();
    flags_all("R6 final");
    summary();
  end
endmodule